// File: doc/BRIEF.md
# Programmable Pixel Channel Extractor

This block turns one raw pixel word, as it leaves a display pixel buffer, into separate 8-bit red, green and blue values. The pixel occupies one to four bytes at the bottom of a 32-bit input word. Those bytes are read in either little-endian or big-endian order. Each colour channel then picks its own bit field out of the pixel, using a programmable starting bit and a programmable field width.

A channel whose width is zero drives a fixed programmable colour instead of pixel data. A field narrower than eight bits is stretched to full intensity by repeating its own bits. A field wider than eight bits keeps its most significant eight bits. The result is registered, so an output beat with its valid flag appears one clock after the input beat.

The format and channel settings are static inputs. They are sampled together with the pixel word on the same edge.

Top module: `pxl_chan_extract`

## Requirements
- R1: While `rstN` is low, `outValid` is 0 and all three colour outputs are 0.
- R2: `outValid` equals the value `inValid` had at the previous rising clock edge. A colour beat is computed from the word and settings sampled at that edge.
- R3: Pixel bit p is bit p of the normalised pixel. In little-endian mode, byte b of the pixel is `inWord[8b+7:8b]`. A channel with offset o and width w selects pixel bits o+w-1 down to o.
- R4: `bppSel` encodes the pixel size as 0 = 1 byte, 1 = 2 bytes, 2 = 3 bytes, 3 = 4 bytes. Call that size n. When `bigEnd` is 1, pixel byte b is taken from input byte n-1-b.
- R5: A channel whose width is 0 outputs its own default colour, whatever the pixel word holds.
- R6: For a width w from 1 to 7, the w field bits fill the output from its MSB downward. The pattern repeats cyclically until all 8 output bits are filled.
- R7: For a width from 8 to 15, the output is the top 8 bits of the field.
- R8: Pixel bits at or above position 8n, including any position above 31, read as 0. Input bytes at or above n have no effect.
- R9: In a cycle where `inValid` is 0, the colour outputs keep their previous values.
- R10: The red, green and blue channels each use only their own offset, width and default settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Pixel word valid |
| inWord | input | 32 | Raw pixel word; the pixel sits in the low bytes |
| bppSel | input | 2 | Bytes per pixel minus one |
| bigEnd | input | 1 | Reverse the used bytes before field extraction |
| redOffset | input | 5 | Red field start bit |
| redWidth | input | 4 | Red field width; 0 selects the default colour |
| redDefault | input | 8 | Red default colour |
| greenOffset | input | 5 | Green field start bit |
| greenWidth | input | 4 | Green field width |
| greenDefault | input | 8 | Green default colour |
| blueOffset | input | 5 | Blue field start bit |
| blueWidth | input | 4 | Blue field width |
| blueDefault | input | 8 | Blue default colour |
| outValid | output | 1 | Colour beat valid |
| outRed | output | 8 | Red value |
| outGreen | output | 8 | Green value |
| outBlue | output | 8 | Blue value |

## Verification
The properties assume that `inValid` is 0 throughout reset. They also assume that the settings seen on a valid beat describe that same beat; the design never reads them later. The bench holds `inValid` low during reset and changes the pixel word and every setting only at the falling edge. The same falling-edge write also sets or clears `inValid`, so each beat's settings are stable at the edge that captures them. The sweep covers every pixel size, both byte orders, all 32 offsets and all 16 widths on red, while green and blue use different derived settings.

// File: rtl/pce_pkg.sv
package pce_pkg;
  localparam int WORD_W = 32;
  localparam int CHAN_W = 8;
  localparam int OFS_W  = 5;
  localparam int WID_W  = 4;
  localparam int BYTES  = WORD_W / 8;
  localparam int BPP_W  = $clog2(BYTES);

  typedef struct packed {
    logic [OFS_W-1:0]  offset;
    logic [WID_W-1:0]  width;
    logic [CHAN_W-1:0] defColor;
  } chanCfg_t;

  typedef struct packed {
    logic              capture;
    logic              swap;
    logic [BPP_W-1:0]  lastByte;
    logic [BYTES-1:0]  byteUse;
  } pceStrobe_t;
endpackage

// File: rtl/pce_ctrl.sv
module pce_ctrl
  import pce_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [BPP_W-1:0] bppSel,
  input  logic             bigEnd,
  output pceStrobe_t       strobe,
  output logic             outValid
);
  // Byte b is part of the pixel when b <= bppSel.
  always_comb begin
    strobe.capture  = inValid;
    strobe.swap     = bigEnd;
    strobe.lastByte = bppSel;
    for (int b = 0; b < BYTES; b++) begin
      strobe.byteUse[b] = (BPP_W'(b) <= bppSel);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/pce_chan.sv
module pce_chan
  import pce_pkg::*;
(
  input  logic [WORD_W-1:0] pixWord,
  input  chanCfg_t          cfg,
  output logic [CHAN_W-1:0] color
);
  localparam int FIELD_W = 2 ** WID_W;
  localparam int POS_W   = OFS_W + 2;

  logic [FIELD_W-1:0] field;
  logic [POS_W-1:0]   pos;

  // Collect the field; positions beyond the word read as zero.
  always_comb begin
    for (int k = 0; k < FIELD_W; k++) begin
      pos = POS_W'(cfg.offset) + POS_W'(k);
      if (WID_W'(k) < cfg.width && pos < POS_W'(WORD_W))
        field[k] = pixWord[pos[OFS_W-1:0]];
      else
        field[k] = 1'b0;
    end
  end

  // Walk the field from its MSB down, wrapping for short fields.
  logic [WID_W-1:0] idx;
  always_comb begin
    idx = cfg.width - WID_W'(1);
    color = '0;
    if (cfg.width == '0) begin
      color = cfg.defColor;
    end else begin
      for (int j = CHAN_W - 1; j >= 0; j--) begin
        color[j] = field[idx];
        idx = (idx == '0) ? cfg.width - WID_W'(1) : idx - WID_W'(1);
      end
    end
  end
endmodule

// File: rtl/pce_datapath.sv
module pce_datapath
  import pce_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pceStrobe_t        strobe,
  input  logic [WORD_W-1:0] inWord,
  input  chanCfg_t          cfg [3],
  output logic [CHAN_W-1:0] colorQ [3]
);
  logic [WORD_W-1:0] normWord;
  logic [BPP_W-1:0]  srcIdx;

  // Keep only the pixel bytes, optionally reversed.
  always_comb begin
    normWord = '0;
    for (int b = 0; b < BYTES; b++) begin
      srcIdx = strobe.swap ? strobe.lastByte - BPP_W'(b) : BPP_W'(b);
      if (strobe.byteUse[b])
        normWord[8*b +: 8] = inWord[8*srcIdx +: 8];
    end
  end

  logic [CHAN_W-1:0] colorD [3];

  for (genvar c = 0; c < 3; c++) begin : g_chan
    pce_chan u_chan (
      .pixWord (normWord),
      .cfg     (cfg[c]),
      .color   (colorD[c])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               colorQ[c] <= '0;
      else if (strobe.capture) colorQ[c] <= colorD[c];
    end
  end
endmodule

// File: rtl/pxl_chan_extract.sv
module pxl_chan_extract
  import pce_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] inWord,
  input  logic [1:0]  bppSel,
  input  logic        bigEnd,
  input  logic [4:0]  redOffset,
  input  logic [3:0]  redWidth,
  input  logic [7:0]  redDefault,
  input  logic [4:0]  greenOffset,
  input  logic [3:0]  greenWidth,
  input  logic [7:0]  greenDefault,
  input  logic [4:0]  blueOffset,
  input  logic [3:0]  blueWidth,
  input  logic [7:0]  blueDefault,
  output logic        outValid,
  output logic [7:0]  outRed,
  output logic [7:0]  outGreen,
  output logic [7:0]  outBlue
);
  pceStrobe_t        strobe;
  chanCfg_t          cfg    [3];
  logic [CHAN_W-1:0] colorQ [3];

  assign cfg[0] = '{offset: redOffset,   width: redWidth,   defColor: redDefault};
  assign cfg[1] = '{offset: greenOffset, width: greenWidth, defColor: greenDefault};
  assign cfg[2] = '{offset: blueOffset,  width: blueWidth,  defColor: blueDefault};

  pce_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .bppSel   (bppSel),
    .bigEnd   (bigEnd),
    .strobe   (strobe),
    .outValid (outValid)
  );

  pce_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .inWord (inWord),
    .cfg    (cfg),
    .colorQ (colorQ)
  );

  assign outRed   = colorQ[0];
  assign outGreen = colorQ[1];
  assign outBlue  = colorQ[2];
endmodule

// File: rtl/pce_checker.sv
module pce_checker (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic [1:0] bppSel,
  input logic [4:0] redOffset,
  input logic [3:0] redWidth,
  input logic [7:0] redDefault,
  input logic [3:0] blueWidth,
  input logic [7:0] blueDefault,
  input logic       outValid,
  input logic [7:0] outRed,
  input logic [7:0] outGreen,
  input logic [7:0] outBlue
);
  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid));

  assert_hold_colors_R9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable({outRed, outGreen, outBlue}));

  assert_red_default_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && redWidth == 4'd0) |=> outRed == $past(redDefault));

  assert_blue_default_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && blueWidth == 4'd0) |=> outBlue == $past(blueDefault));

  assert_high_bits_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && bppSel == 2'd0 && redOffset >= 5'd8 && redWidth != 4'd0) |=> outRed == 8'd0);
endmodule

bind pxl_chan_extract pce_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .inValid     (inValid),
  .bppSel      (bppSel),
  .redOffset   (redOffset),
  .redWidth    (redWidth),
  .redDefault  (redDefault),
  .blueWidth   (blueWidth),
  .blueDefault (blueDefault),
  .outValid    (outValid),
  .outRed      (outRed),
  .outGreen    (outGreen),
  .outBlue     (outBlue)
);

// File: tb/pxl_chan_extract_tb.sv
`timescale 1ns/1ps
module pxl_chan_extract_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [31:0] inWord = '0;
  logic [1:0] bppSel = '0;
  logic bigEnd = 1'b0;
  logic [4:0] redOffset = '0, greenOffset = '0, blueOffset = '0;
  logic [3:0] redWidth = '0, greenWidth = '0, blueWidth = '0;
  logic [7:0] redDefault = '0, greenDefault = '0, blueDefault = '0;
  logic outValid;
  logic [7:0] outRed, outGreen, outBlue;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  pxl_chan_extract u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord),
    .bppSel(bppSel), .bigEnd(bigEnd),
    .redOffset(redOffset), .redWidth(redWidth), .redDefault(redDefault),
    .greenOffset(greenOffset), .greenWidth(greenWidth), .greenDefault(greenDefault),
    .blueOffset(blueOffset), .blueWidth(blueWidth), .blueDefault(blueDefault),
    .outValid(outValid), .outRed(outRed), .outGreen(outGreen), .outBlue(outBlue)
  );

  function automatic logic [7:0] model(input logic [31:0] w, input int bpp, input bit be,
                                       input int off, input int wid, input logic [7:0] def);
    longint unsigned pix = 0;
    longint unsigned val;
    longint unsigned acc = 0;
    int n = bpp + 1;
    int bits = 0;
    for (int b = 0; b < n; b++) begin
      int src = be ? (n - 1 - b) : b;
      pix = pix + (longint'((w >> (8 * src)) & 32'hFF) << (8 * b));
    end
    if (wid == 0) return def;
    val = (pix >> off) & ((64'd1 << wid) - 1);
    if (wid >= 8) return 8'(val >> (wid - 8));
    while (bits < 8) begin
      acc = (acc << wid) | val;
      bits = bits + wid;
    end
    return 8'(acc >> (bits - 8));
  endfunction

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] lcg = 32'h1234_5678;
    logic [7:0] expR, expG, expB, holdR, holdG, holdB;
    string tag;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    check("R1", "outValid", {7'd0, outValid}, 8'd0);
    check("R1", "outRed", outRed, 8'd0);
    check("R1", "outGreen", outGreen, 8'd0);
    check("R1", "outBlue", outBlue, 8'd0);
    @(negedge clk);
    rstN = 1'b1;
    redDefault = 8'hA5;
    greenDefault = 8'h3C;
    blueDefault = 8'hC3;

    for (int bpp = 0; bpp < 4; bpp++) begin
      for (int be = 0; be < 2; be++) begin
        for (int off = 0; off < 32; off++) begin
          for (int wid = 0; wid < 16; wid++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            @(negedge clk);
            inValid = 1'b1;
            inWord = lcg;
            bppSel = 2'(bpp);
            bigEnd = 1'(be);
            redOffset = 5'(off);
            redWidth = 4'(wid);
            greenOffset = 5'((off * 7 + 3) % 32);
            greenWidth = 4'((wid + 5) % 16);
            blueOffset = 5'(31 - off);
            blueWidth = 4'(15 - wid);
            expR = model(lcg, bpp, 1'(be), off, wid, redDefault);
            expG = model(lcg, bpp, 1'(be), int'(greenOffset), int'(greenWidth), greenDefault);
            expB = model(lcg, bpp, 1'(be), int'(blueOffset), int'(blueWidth), blueDefault);
            if (wid == 0) tag = "R5";
            else if (off + wid > 8 * (bpp + 1)) tag = "R8";
            else if (be != 0) tag = "R4";
            else if (wid == 8) tag = "R3";
            else if (wid < 8) tag = "R6";
            else tag = "R7";
            @(posedge clk);
            #1;
            check("R2", "outValid", {7'd0, outValid}, 8'd1);
            check(tag, "outRed", outRed, expR);
            check("R10", "outGreen", outGreen, expG);
            check("R10", "outBlue", outBlue, expB);
          end
        end
      end
    end

    // R9: no valid beat leaves the colours untouched
    holdR = outRed; holdG = outGreen; holdB = outBlue;
    @(negedge clk);
    inValid = 1'b0;
    inWord = ~inWord;
    redWidth = 4'd0; greenWidth = 4'd0; blueWidth = 4'd0;
    redDefault = 8'h11; greenDefault = 8'h22; blueDefault = 8'h33;
    @(posedge clk); #1;
    check("R2", "outValid low", {7'd0, outValid}, 8'd0);
    @(posedge clk); #1;
    check("R9", "outRed hold", outRed, holdR);
    check("R9", "outGreen hold", outGreen, holdG);
    check("R9", "outBlue hold", outBlue, holdB);

    done = 1'b1;
    summary();
  end
endmodule